// File: doc/BRIEF.md
# Dual GPIO Port with Combined Falling-Edge Interrupt

This block holds two 8-bit bidirectional I/O ports, called port 0 and port 1. Each port has a stored output value and a direction mask, and both are reached over a small register bus. A pin whose direction bit is 1 is driven from the stored value. A pin whose direction bit is 0 is sampled through a two-stage synchronizer.

For each port, the synchronized levels of the input pins are combined with an AND into one signal. Output pins count as logic 1 in that AND. When the combined signal falls from 1 to 0, the port's own interrupt flag is set. The two flags are ORed into a single interrupt request for the processor. Software reads both flags in one status register, and clears each one separately by writing 1 to its bit.

Because the pins are combined with an AND, an input pin held low keeps the combined signal low. While that is so, falling edges on the other input pins of the same port go unnoticed. The layout of the register bus is 0x0 port 0 value, 0x2 port 1 value, 0x4 port 0 direction, 0x6 port 1 direction and 0x7 interrupt status. Writes to any other address have no effect, and reads of them return 0.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset, both direction registers read 0x00, both pin_oe outputs are 0x00, the status register reads 0x00 and irq is low.
- R2: A write to a direction register (0x4 for port 0, 0x6 for port 1) sets that port's pin_oe output on the next clock, and a read of the register returns it. pin_oe changes at no other time except reset.
- R3: A read of a port value address returns, for each bit, the stored value where the direction bit is 1 and the synchronized pin level where the direction bit is 0. The pin level shows up 2 clocks after it changes.
- R4: A write to a port value address always updates the stored value, including on bits that are currently inputs, and pin_out shows the stored value.
- R5: When the AND of a port's input pins falls from 1 to 0, the port's flag is set. Flag bit 0 belongs to port 0 and bit 1 to port 1. The flag is set 3 clocks after the pin change reaches the port.
- R6: Pins whose direction bit is 1 are left out of the AND, so a falling level on an output pin never sets a flag.
- R7: While any input pin of a port stays low, a falling edge on another input pin of that port does not set the flag.
- R8: A steady low level does not set the flag again after it has been cleared, and a rising edge never sets it.
- R9: Each port sets only its own flag, and the two flags can be set and cleared independently.
- R10: Writing 1 to a status bit at 0x7 clears that flag. Writing 0 leaves it unchanged.
- R11: If a new edge and a clear of the same flag fall in the same cycle, the flag stays set.
- R12: irq equals the OR of the two flags, and status bits 7..2 read 0. Reset clears the flags and the direction registers, but it does not change the stored port values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in_0 | input | 8 | Pad input levels, port 0 |
| pin_out_0 | output | 8 | Pad output values, port 0 |
| pin_oe_0 | output | 8 | Pad output enables, port 0 |
| pin_in_1 | input | 8 | Pad input levels, port 1 |
| pin_out_1 | output | 8 | Pad output values, port 1 |
| pin_oe_1 | output | 8 | Pad output enables, port 1 |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle the flag is set again. The bench arranges this by counting the synchronizer and edge stages: it lowers a pin, waits exactly one edge, and then issues the clear write so that the write is sampled on the edge where the flag loads. The masking rule is reached by first leaving one input low, then clearing the flag, and then lowering a second input. A reset is applied in the middle of the run to show that the stored value survives while the flags and direction registers are cleared.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 3;
  localparam int NPORT  = 2;

  localparam logic [ADDR_W-1:0] A_VAL0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_VAL1 = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIR0 = 3'd4;
  localparam logic [ADDR_W-1:0] A_DIR1 = 3'd6;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd7;

  typedef struct packed {
    logic val_we;
    logic dir_we;
  } port_wr_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  logic [W-1:0] s1_d, s2_d;

  always_comb begin
    s1_d = d;
    s2_d = s1_q;
  end

  // idle-high reset value so reset release never looks like an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_irq_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  port_wr_t     wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] dir,
  output logic         fall
);
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] val_q, val_d;
  logic [W-1:0] pin_s;
  logic         comb_and;
  logic         prev_q, prev_d;

  gpio_sync #(.W(W)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pin_s)
  );

  always_comb begin
    dir_d  = wr.dir_we ? wdata : dir_q;
    val_d  = wr.val_we ? wdata : val_q;
    comb_and = &(pin_s | dir_q);
    prev_d = comb_and;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      prev_q <= 1'b1;
    end else begin
      dir_q  <= dir_d;
      prev_q <= prev_d;
    end
  end

  // stored value is deliberately not reset
  always_ff @(posedge clk) begin
    val_q <= val_d;
  end

  assign fall    = prev_q & ~comb_and;
  assign pin_out = val_q;
  assign pin_oe  = dir_q;
  assign dir     = dir_q;
  assign rd_val  = (val_q & dir_q) | (pin_s & ~dir_q);
endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  logic [N-1:0] flag_q, flag_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      flag_d[i] = (flag_q[i] & ~clr[i]) | set[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int W  = PORT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in_0,
  output logic [W-1:0]  pin_out_0,
  output logic [W-1:0]  pin_oe_0,
  input  logic [W-1:0]  pin_in_1,
  output logic [W-1:0]  pin_out_1,
  output logic [W-1:0]  pin_oe_1,
  output logic          irq
);
  localparam logic [AW-1:0] VAL_ADDR [NPORT] = '{A_VAL0, A_VAL1};
  localparam logic [AW-1:0] DIR_ADDR [NPORT] = '{A_DIR0, A_DIR1};

  logic                 wr_en;
  logic [NPORT-1:0]     fall;
  logic [NPORT-1:0]     clr;
  logic [NPORT-1:0]     flag;
  logic [W-1:0]         pin_in  [NPORT];
  logic [W-1:0]         pin_out [NPORT];
  logic [W-1:0]         pin_oe  [NPORT];
  logic [W-1:0]         rd_val  [NPORT];
  logic [W-1:0]         dir     [NPORT];
  port_wr_t             pwr     [NPORT];

  assign wr_en     = bus_sel & bus_wr;
  assign pin_in[0] = pin_in_0;
  assign pin_in[1] = pin_in_1;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      always_comb begin
        pwr[p].val_we = wr_en && (bus_addr == VAL_ADDR[p]);
        pwr[p].dir_we = wr_en && (bus_addr == DIR_ADDR[p]);
      end

      gpio_port #(.W(W)) i_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (pwr[p]),
        .wdata  (bus_wdata),
        .pin_in (pin_in[p]),
        .pin_out(pin_out[p]),
        .pin_oe (pin_oe[p]),
        .rd_val (rd_val[p]),
        .dir    (dir[p]),
        .fall   (fall[p])
      );
    end
  endgenerate

  assign clr = (wr_en && (bus_addr == A_STAT)) ? bus_wdata[NPORT-1:0] : '0;

  gpio_irq_latch #(.N(NPORT)) i_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (fall),
    .clr  (clr),
    .flag (flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_VAL0:  bus_rdata = rd_val[0];
        A_VAL1:  bus_rdata = rd_val[1];
        A_DIR0:  bus_rdata = dir[0];
        A_DIR1:  bus_rdata = dir[1];
        A_STAT:  bus_rdata = {{(W-NPORT){1'b0}}, flag};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out_0 = pin_out[0];
  assign pin_oe_0  = pin_oe[0];
  assign pin_out_1 = pin_out[1];
  assign pin_oe_1  = pin_oe[1];
  assign irq       = |flag;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pin_oe_0,
  input logic [W-1:0]  pin_oe_1,
  input logic          irq
);
  logic wr_dir0, wr_dir1, wr_stat, rd_stat, rd_dir0;
  assign wr_dir0 = bus_sel && bus_wr && (bus_addr == 3'd4);
  assign wr_dir1 = bus_sel && bus_wr && (bus_addr == 3'd6);
  assign wr_stat = bus_sel && bus_wr && (bus_addr == 3'd7);
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == 3'd7);
  assign rd_dir0 = bus_sel && !bus_wr && (bus_addr == 3'd4);

  // R2
  oe0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_dir0) |-> $stable(pin_oe_0));

  // R2
  oe1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_dir1) |-> $stable(pin_oe_1));

  // R2
  dir0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dir0 |-> (bus_rdata == pin_oe_0));

  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_stat));

  // R12
  stat_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> ((bus_rdata[W-1:2] == '0) && (irq == (|bus_rdata[1:0]))));
endmodule

bind gpio_irq_top gpio_irq_chk #(.W(W), .AW(AW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_oe_0 (pin_oe_0),
  .pin_oe_1 (pin_oe_1),
  .irq      (irq)
);

// File: tb/test_gpio_irq_top.sv
module test_gpio_irq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pa = 8'hFF;
  logic [7:0] pb = 8'hFF;
  logic [7:0] pin_out_0, pin_oe_0, pin_out_1, pin_oe_1;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int         src;   // 0 rdata, 1 irq, 2 pin_out_0, 3 pin_oe_0
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  gpio_irq_top i_gpio_irq_top (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in_0(pa), .pin_out_0(pin_out_0), .pin_oe_0(pin_oe_0),
    .pin_in_1(pb), .pin_out_1(pin_out_1), .pin_oe_1(pin_oe_1),
    .irq(irq)
  );

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.src)
        0: act = bus_rdata;
        1: act = {7'b0, irq};
        2: act = pin_out_0;
        default: act = pin_oe_0;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s src%0d actual=%02h expected=%02h", it.req, it.src, act, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string r);
    item_t it;
    @(posedge clk); #2;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    it.src = 0; it.exp = e; it.req = r;
    q.push_back(it);
    @(posedge clk); #2;
    bus_sel = 0;
  endtask

  task automatic see(input int s, input logic [7:0] e, input string r);
    item_t it;
    @(posedge clk); #2;
    it.src = s; it.exp = e; it.req = r;
    q.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(3);
    // R1 reset state
    rd(3'd4, 8'h00, "R1");
    rd(3'd6, 8'h00, "R1");
    rd(3'd7, 8'h00, "R1");
    see(1, 8'h00, "R1");
    see(3, 8'h00, "R1");
    // R2 direction and value
    wr(3'd4, 8'hF0);
    wr(3'd0, 8'hA5);
    see(3, 8'hF0, "R2");
    rd(3'd4, 8'hF0, "R2");
    see(2, 8'hA5, "R4");
    // R3 mixed readback; low inputs also make the AND fall (R5)
    pa = 8'h3C;
    idle(4);
    rd(3'd0, 8'hAC, "R3");
    rd(3'd7, 8'h01, "R5");
    see(1, 8'h01, "R12");
    wr(3'd7, 8'h01);
    rd(3'd7, 8'h00, "R10");
    // R8 steady low does not retrigger
    idle(5);
    rd(3'd7, 8'h00, "R8");
    // R7 masking: bits 0,1 held low, now bit 2 falls
    pa = 8'h38;
    idle(5);
    rd(3'd7, 8'h00, "R7");
    pa = 8'hFF;
    idle(5);
    rd(3'd7, 8'h00, "R8");
    // R6 output pins 7..4 falling
    pa = 8'h0F;
    idle(5);
    rd(3'd7, 8'h00, "R6");
    pa = 8'hFF;
    idle(5);
    // R4 write updates stored value on input bits
    wr(3'd0, 8'h11);
    rd(3'd0, 8'h1F, "R4");
    wr(3'd4, 8'hFF);
    rd(3'd0, 8'h11, "R4");
    see(2, 8'h11, "R4");
    // R9 independent flags
    pb = 8'hFE;
    idle(5);
    rd(3'd7, 8'h02, "R9");
    see(1, 8'h01, "R12");
    wr(3'd4, 8'h00);
    pa = 8'h7F;
    idle(5);
    rd(3'd7, 8'h03, "R9");
    wr(3'd7, 8'h01);
    rd(3'd7, 8'h02, "R9");
    wr(3'd7, 8'h00);
    rd(3'd7, 8'h02, "R10");
    wr(3'd7, 8'h02);
    rd(3'd7, 8'h00, "R10");
    see(1, 8'h00, "R12");
    // R11 set wins over clear
    pa = 8'hFF; pb = 8'hFF;
    idle(5);
    pa = 8'hFE;
    idle(5);
    rd(3'd7, 8'h01, "R5");
    pa = 8'hFF;
    idle(5);
    @(posedge clk); #2;
    pa = 8'hFE;
    @(posedge clk);
    wr(3'd7, 8'h01);
    rd(3'd7, 8'h01, "R11");
    wr(3'd7, 8'h01);
    rd(3'd7, 8'h00, "R11");
    // R12 reset keeps stored value
    wr(3'd0, 8'h5A);
    pa = 8'hFF;
    pb = 8'hFE;
    idle(5);
    rd(3'd7, 8'h02, "R9");
    pb = 8'hFF;
    idle(2);
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(3);
    rd(3'd4, 8'h00, "R12");
    rd(3'd7, 8'h00, "R12");
    see(1, 8'h00, "R12");
    wr(3'd4, 8'hFF);
    rd(3'd0, 8'h5A, "R12");
    idle(3);
    done = 1;
    finish_run();
  end
endmodule